// File: doc/BRIEF.md
# Parallel Prototype Distance Matcher

This block sits after a time-surface generator. It takes one surface value per clock for each neighbourhood position of an event. Every prototype lane holds a stored surface of its own. A lane reads its value at the same neighbourhood position as the incoming sample, squares the absolute difference and adds it to a running sum. The lanes work in parallel, one per prototype.

When the last sample of an event has been added, every lane starts an iterative non-restoring square root at the same time. Each iteration settles one root bit with a single add or subtract and a shift. When the roots are ready, an argmin stage picks the closest prototype. The block then emits one output event. That event carries the event's column, row and timestamp, with the winning prototype index in place of the polarity, and the winning distance beside it.

Prototype values are loaded through a simple write port, one value per cycle. The stage that reads the stored prototype runs one neighbour behind the incoming sample stream, so surface generation and distance accumulation overlap.

Top module: `surf_proto_match`

## Requirements
- R1: While reset is held and after it is released, `o_valid` is 0 until an event has completed.
- R2: `o_dist` equals floor(sqrt(S)) for the winning prototype. S is the sum, over all accepted samples of the event, of (`s_val` − stored value at `s_pos`)², computed without loss for 25 samples of 8-bit values.
- R3: `o_id` is the prototype index whose distance is smallest among the 8 prototypes.
- R4: When several prototypes share the smallest distance, `o_id` is the lowest of their indices.
- R5: `o_x`, `o_y` and `o_ts` equal the `s_x`, `s_y` and `s_ts` presented with the sample flagged `s_first` of that event. Values presented with later samples are not used.
- R6: `o_valid` is a one-cycle pulse. Let A be the clock edge that accepts the sample flagged `s_last`. The pulse is high in the cycle after edge A+13, where 13 = ACC_W/2+2 and ACC_W=22 is the accumulator width.
- R7: A sample flagged `s_first` restarts every sum, so back-to-back events with no idle cycle do not mix.
- R8: A cycle with `cfg_we`=1 stores `cfg_val` as the value of prototype `cfg_id` at position `cfg_pos`. Later events use the new value.
- R9: Cycles with `s_valid`=0 do not change any sum, whatever the other stream inputs carry.
- R10: An event of a single sample, flagged both `s_first` and `s_last`, produces a correct output event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Prototype write strobe |
| cfg_id | input | 3 | Prototype index to write |
| cfg_pos | input | 5 | Neighbourhood position to write |
| cfg_val | input | 8 | Prototype value |
| s_valid | input | 1 | Surface sample valid |
| s_first | input | 1 | First sample of an event |
| s_last | input | 1 | Last sample of an event |
| s_pos | input | 5 | Neighbourhood position of the sample (0..24) |
| s_val | input | 8 | Surface value |
| s_x | input | 7 | Event column |
| s_y | input | 7 | Event row |
| s_ts | input | 32 | Event timestamp |
| o_valid | output | 1 | Output event strobe |
| o_x | output | 7 | Output event column |
| o_y | output | 7 | Output event row |
| o_ts | output | 32 | Output event timestamp |
| o_id | output | 3 | Winning prototype index |
| o_dist | output | 11 | Winning distance, floor of the square root |

## Verification
The latency and single-pulse properties rely on one input assumption. Two accepted `s_last` samples must be at least ACC_W/2+3 cycles apart, so a second root computation never starts before the first result has left. A prototype write must not target the position being read in the same cycle, and `s_pos` must stay below 25. The stimulus satisfies all of this by construction. Full events span 25 samples. Single-sample events are followed by an idle gap longer than the root latency. All prototype writes happen while the stream is idle.

// File: rtl/proto_match_pkg.sv
package proto_match_pkg;
   // Even accumulator width holding NBR squared differences of val_w-bit values.
   function automatic int acc_width(input int val_w, input int nbr);
      int w;
      w = 2 * val_w + $clog2(nbr);
      return w + (w % 2);
   endfunction
endpackage

// File: rtl/pm_sqrt_nr.sv
module pm_sqrt_nr #(
   parameter int ACC_W = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [ACC_W-1:0]     rad,
   output logic [ACC_W/2-1:0]   root,
   output logic                 done
);
   localparam int RW    = ACC_W / 2;
   localparam int CNT_W = $clog2(RW + 1);

   if (ACC_W % 2 != 0) $error("pm_sqrt_nr: ACC_W must be even");
   if (RW < 2)         $error("pm_sqrt_nr: ACC_W too small");

   logic [ACC_W-1:0] d_q;
   logic [RW+1:0]    r_q, r_sh, r_tq, r_nx;
   logic [RW-1:0]    q_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_comb begin
      r_sh = {r_q[RW-1:0], d_q[ACC_W-1 -: 2]};
      r_tq = {q_q, r_q[RW+1], 1'b1};
      r_nx = r_q[RW+1] ? (r_sh + r_tq) : (r_sh - r_tq);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_q    <= '0;
         r_q    <= '0;
         q_q    <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            d_q    <= rad;
            r_q    <= '0;
            q_q    <= '0;
            cnt_q  <= CNT_W'(RW);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            d_q   <= d_q << 2;
            r_q   <= r_nx;
            q_q   <= {q_q[RW-2:0], ~r_nx[RW+1]};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign root = q_q;
endmodule

// File: rtl/pm_dist_lane.sv
module pm_dist_lane #(
   parameter int VAL_W = 8,
   parameter int NBR   = 25,
   parameter int ACC_W = 22
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(NBR)-1:0]   wr_pos,
   input  logic [VAL_W-1:0]         wr_val,
   input  logic [$clog2(NBR)-1:0]   rd_pos,
   input  logic                     p1_valid,
   input  logic                     p1_first,
   input  logic                     p1_last,
   input  logic [VAL_W-1:0]         p1_val,
   output logic [ACC_W/2-1:0]       root,
   output logic                     done
);
   if (ACC_W < 2 * VAL_W + 2) $error("pm_dist_lane: accumulator too narrow");

   logic [VAL_W-1:0]   mem [NBR];
   logic [VAL_W-1:0]   proto_q;
   logic [VAL_W-1:0]   adiff;
   logic [2*VAL_W-1:0] sq;
   logic [ACC_W-1:0]   acc_q, acc_nx;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_pos] <= wr_val;
      proto_q <= mem[rd_pos];
   end

   always_comb begin
      adiff  = (p1_val > proto_q) ? (p1_val - proto_q) : (proto_q - p1_val);
      sq     = adiff * adiff;
      acc_nx = (p1_first ? '0 : acc_q) + {{(ACC_W-2*VAL_W){1'b0}}, sq};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        acc_q <= '0;
      else if (p1_valid) acc_q <= acc_nx;
   end

   pm_sqrt_nr #(.ACC_W(ACC_W)) u_sqrt (
      .clk   (clk),
      .rst_n (rst_n),
      .start (p1_valid & p1_last),
      .rad   (acc_nx),
      .root  (root),
      .done  (done)
   );
endmodule

// File: rtl/pm_min_sel.sv
module pm_min_sel #(
   parameter int N  = 8,
   parameter int RW = 11
) (
   input  logic [N*RW-1:0]      vals,
   output logic [$clog2(N)-1:0] idx,
   output logic [RW-1:0]        min_val
);
   always_comb begin
      idx     = '0;
      min_val = vals[RW-1:0];
      for (int i = 1; i < N; i++) begin
         if (vals[i*RW +: RW] < min_val) begin
            min_val = vals[i*RW +: RW];
            idx     = ($clog2(N))'(i);
         end
      end
   end
endmodule

// File: rtl/surf_proto_match.sv
module surf_proto_match
   import proto_match_pkg::*;
#(
   parameter int N_PROTO = 8,
   parameter int VAL_W   = 8,
   parameter int NBR     = 25,
   parameter int X_W     = 7,
   parameter int Y_W     = 7,
   parameter int TS_W    = 32,
   localparam int ID_W   = $clog2(N_PROTO),
   localparam int POS_W  = $clog2(NBR),
   localparam int ACC_W  = acc_width(VAL_W, NBR),
   localparam int RW     = ACC_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [ID_W-1:0]  cfg_id,
   input  logic [POS_W-1:0] cfg_pos,
   input  logic [VAL_W-1:0] cfg_val,
   input  logic             s_valid,
   input  logic             s_first,
   input  logic             s_last,
   input  logic [POS_W-1:0] s_pos,
   input  logic [VAL_W-1:0] s_val,
   input  logic [X_W-1:0]   s_x,
   input  logic [Y_W-1:0]   s_y,
   input  logic [TS_W-1:0]  s_ts,
   output logic             o_valid,
   output logic [X_W-1:0]   o_x,
   output logic [Y_W-1:0]   o_y,
   output logic [TS_W-1:0]  o_ts,
   output logic [ID_W-1:0]  o_id,
   output logic [RW-1:0]    o_dist
);
   if (N_PROTO < 2) $error("surf_proto_match: need at least two prototypes");
   if (NBR < 2)     $error("surf_proto_match: need at least two positions");

   typedef struct packed {
      logic [X_W-1:0]  x;
      logic [Y_W-1:0]  y;
      logic [TS_W-1:0] ts;
   } ev_t;

   logic             p1_valid, p1_first, p1_last;
   logic [VAL_W-1:0] p1_val;
   ev_t              ev_hold, sq_ev;
   logic             sq_start, sq_done;
   logic [N_PROTO-1:0]    done_vec;
   logic [N_PROTO*RW-1:0] root_flat;
   logic [ID_W-1:0]  win_id;
   logic [RW-1:0]    win_dist;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p1_valid <= 1'b0;
         p1_first <= 1'b0;
         p1_last  <= 1'b0;
         p1_val   <= '0;
         ev_hold  <= '0;
      end else begin
         p1_valid <= s_valid;
         p1_first <= s_valid & s_first;
         p1_last  <= s_valid & s_last;
         p1_val   <= s_val;
         if (s_valid && s_first) ev_hold <= '{x: s_x, y: s_y, ts: s_ts};
      end
   end

   assign sq_start = p1_valid & p1_last;

   for (genvar g = 0; g < N_PROTO; g++) begin : g_lane
      pm_dist_lane #(.VAL_W(VAL_W), .NBR(NBR), .ACC_W(ACC_W)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we && (cfg_id == ID_W'(g))),
         .wr_pos   (cfg_pos),
         .wr_val   (cfg_val),
         .rd_pos   (s_pos),
         .p1_valid (p1_valid),
         .p1_first (p1_first),
         .p1_last  (p1_last),
         .p1_val   (p1_val),
         .root     (root_flat[g*RW +: RW]),
         .done     (done_vec[g])
      );
   end

   assign sq_done = &done_vec;

   pm_min_sel #(.N(N_PROTO), .RW(RW)) u_min (
      .vals    (root_flat),
      .idx     (win_id),
      .min_val (win_dist)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sq_ev   <= '0;
         o_valid <= 1'b0;
         o_x     <= '0;
         o_y     <= '0;
         o_ts    <= '0;
         o_id    <= '0;
         o_dist  <= '0;
      end else begin
         if (sq_start) sq_ev <= ev_hold;
         o_valid <= sq_done;
         if (sq_done) begin
            o_x    <= sq_ev.x;
            o_y    <= sq_ev.y;
            o_ts   <= sq_ev.ts;
            o_id   <= win_id;
            o_dist <= win_dist;
         end
      end
   end
endmodule

// File: rtl/pm_match_chk.sv
module pm_match_chk #(
   parameter int N_PROTO = 8,
   parameter int RW      = 11,
   parameter int ID_W    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sq_start,
   input logic                  sq_done,
   input logic [N_PROTO*RW-1:0] roots,
   input logic                  o_valid,
   input logic [ID_W-1:0]       o_id,
   input logic [RW-1:0]         o_dist
);
   int lat_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 lat_cnt <= RW + 100;
      else if (sq_start)          lat_cnt <= 0;
      else if (lat_cnt < RW + 100) lat_cnt <= lat_cnt + 1;
   end

   AST_DONE_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      sq_done |=> o_valid); // R6
   AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |=> !o_valid); // R6
   AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> lat_cnt == RW + 1); // R6

   for (genvar k = 0; k < N_PROTO; k++) begin : g_lane_chk
      AST_WIN_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
         sq_done |=> o_dist <= $past(roots[k*RW +: RW])); // R3
      AST_TIE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
         sq_done |=> ($past(roots[k*RW +: RW]) != o_dist) || (o_id <= ID_W'(k))); // R4
   end
endmodule

bind surf_proto_match pm_match_chk #(.N_PROTO(N_PROTO), .RW(RW), .ID_W(ID_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sq_start (sq_start),
   .sq_done  (sq_done),
   .roots    (root_flat),
   .o_valid  (o_valid),
   .o_id     (o_id),
   .o_dist   (o_dist)
);

// File: tb/surf_proto_match_test.sv
`timescale 1ns/1ps
module surf_proto_match_test;
   localparam int NP  = 8;
   localparam int NBR = 25;
   localparam int RW  = 11;
   localparam int LAT = RW + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_id = '0;
   logic [4:0]  cfg_pos = '0;
   logic [7:0]  cfg_val = '0;
   logic        s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
   logic [4:0]  s_pos = '0;
   logic [7:0]  s_val = '0;
   logic [6:0]  s_x = '0, s_y = '0;
   logic [31:0] s_ts = '0;
   logic        o_valid;
   logic [6:0]  o_x, o_y;
   logic [31:0] o_ts;
   logic [2:0]  o_id;
   logic [10:0] o_dist;

   always #4 clk = ~clk;

   surf_proto_match uut (.*);

   int checks = 0, fails = 0, cyc = 0;
   int proto [NP][NBR];
   int lcg = 12345;
   bit monitor_on = 1'b0;

   int    q_due[$], q_x[$], q_y[$], q_ts[$], q_id[$], q_dist[$];
   string q_tag[$];

   function automatic int rnd8();
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      return (lcg >> 8) & 255;
   endfunction

   function automatic int isqrt(input int s);
      int r = 0;
      while ((r + 1) * (r + 1) <= s) r++;
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int id, input int pos, input int val);
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_id = 3'(id); cfg_pos = 5'(pos); cfg_val = 8'(val);
      proto[id][pos] = val;
      @(posedge clk); #2;
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
      end
   endtask

   // Drives one event; vals[p] is the surface at position p, for p < npix.
   // gaps inserts an invalid cycle with junk after every third sample.
   task automatic send_event(input int vals[NBR], input int npix, input int x,
                             input int y, input int ts, input bit gaps, input string tag);
      int sum [NP];
      int best, bestd, d;
      for (int k = 0; k < NP; k++) sum[k] = 0;
      for (int p = 0; p < npix; p++) begin
         @(posedge clk); #2;
         s_valid = 1'b1; s_first = (p == 0); s_last = (p == npix - 1);
         s_pos = 5'(p); s_val = 8'(vals[p]);
         s_x = (p == 0) ? 7'(x) : 7'(rnd8());
         s_y = (p == 0) ? 7'(y) : 7'(rnd8());
         s_ts = (p == 0) ? ts : rnd8();
         for (int k = 0; k < NP; k++)
            sum[k] += (vals[p] - proto[k][p]) * (vals[p] - proto[k][p]);
         if (p == npix - 1) begin
            best = 0; bestd = isqrt(sum[0]);
            for (int k = 1; k < NP; k++) begin
               d = isqrt(sum[k]);
               if (d < bestd) begin bestd = d; best = k; end
            end
            q_due.push_back(cyc + 2 + LAT);
            q_x.push_back(x); q_y.push_back(y); q_ts.push_back(ts);
            q_id.push_back(best); q_dist.push_back(bestd); q_tag.push_back(tag);
         end
         if (gaps && p % 3 == 2 && p != npix - 1) begin
            @(posedge clk); #2;
            s_valid = 1'b0; s_first = 1'b1; s_last = 1'b1;
            s_pos = 5'(p); s_val = 8'(rnd8());
         end
      end
   endtask

   // Every-cycle comparison against the reference queue.
   always @(negedge clk) begin
      cyc++;
      if (monitor_on) begin
         if (q_due.size() != 0 && q_due[0] == cyc) begin
            check(o_valid == 1'b1, "R6", "o_valid at due cycle", int'(o_valid), 1);
            check(o_x == 7'(q_x[0]), "R5", "o_x", int'(o_x), q_x[0]);
            check(o_y == 7'(q_y[0]), "R5", "o_y", int'(o_y), q_y[0]);
            check(o_ts == q_ts[0], "R5", "o_ts", int'(o_ts), q_ts[0]);
            check(o_id == 3'(q_id[0]), q_tag[0], "o_id", int'(o_id), q_id[0]);
            check(o_dist == 11'(q_dist[0]), q_tag[0], "o_dist", int'(o_dist), q_dist[0]);
            void'(q_due.pop_front()); void'(q_x.pop_front()); void'(q_y.pop_front());
            void'(q_ts.pop_front()); void'(q_id.pop_front()); void'(q_dist.pop_front());
            void'(q_tag.pop_front());
         end else begin
            check(o_valid == 1'b0, "R6", "o_valid outside due cycle", int'(o_valid), 0);
         end
      end
   end

   initial begin
      #800000;
      fails++;
      $display("FAIL R6 watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int v [NBR];
      for (int k = 0; k < NP; k++)
         for (int p = 0; p < NBR; p++) proto[k][p] = 0;
      repeat (3) @(posedge clk);
      #1;
      check(o_valid == 1'b0, "R1", "o_valid in reset", int'(o_valid), 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      @(negedge clk);
      check(o_valid == 1'b0, "R1", "o_valid after reset", int'(o_valid), 0);
      monitor_on = 1'b1;

      // R8: load all prototypes through the write port
      for (int k = 0; k < NP; k++)
         for (int p = 0; p < NBR; p++) cfg_write(k, p, (k * 37 + p * 11 + k * p) & 255);
      idle(2);

      // R3: surface equal to prototype 3 -> distance 0, winner 3
      for (int p = 0; p < NBR; p++) v[p] = proto[3][p];
      send_event(v, NBR, 5, 9, 1000, 1'b0, "R3");
      // R2 R7: back-to-back pseudo-random events
      for (int e = 0; e < 6; e++) begin
         for (int p = 0; p < NBR; p++) v[p] = rnd8();
         send_event(v, NBR, e + 20, 127 - e, 5000 + e * 77, 1'b0, "R7");
      end
      // R9: invalid cycles with junk inside an event
      for (int p = 0; p < NBR; p++) v[p] = (proto[6][p] + 3) & 255;
      send_event(v, NBR, 64, 33, 32'h7fff0000, 1'b1, "R9");
      idle(LAT + 4);

      // R4 R8: make prototypes 2 and 5 identical, surface matches them
      for (int p = 0; p < NBR; p++) begin
         cfg_write(2, p, (p * 13) & 255);
         cfg_write(5, p, (p * 13) & 255);
      end
      idle(2);
      for (int p = 0; p < NBR; p++) v[p] = (p * 13) & 255;
      send_event(v, NBR, 1, 2, 42, 1'b0, "R4");
      idle(LAT + 4);

      // R2: widest sums, prototypes 0 and 7 at the extremes
      for (int p = 0; p < NBR; p++) begin
         cfg_write(0, p, 0);
         cfg_write(7, p, 255);
      end
      idle(2);
      for (int p = 0; p < NBR; p++) v[p] = 255;
      send_event(v, NBR, 127, 127, 32'hffffffff, 1'b0, "R2");
      for (int p = 0; p < NBR; p++) v[p] = 128;
      send_event(v, NBR, 0, 0, 7, 1'b0, "R2");
      idle(LAT + 4);

      // R10: single-sample events with idle gaps
      for (int e = 0; e < 4; e++) begin
         for (int p = 0; p < NBR; p++) v[p] = rnd8();
         send_event(v, 1, 10 + e, 20 + e, 900 + e, 1'b0, "R10");
         idle(LAT + 4);
      end

      idle(LAT + 6);
      check(q_due.size() == 0, "R6", "pending outputs at end", q_due.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule